// File: doc/BRIEF.md
# Random Output Word Sequencer

This block sequences the read-out of a random-number generator. A write to its control word can reseed the generator or produce a new 256-bit block. The block is then handed out as eight 32-bit words through a read-only output port. The generator itself sits outside. It can be any deterministic word source that shows its current word on `gen_word_i`, moves to the next word on `gen_next_o` and restarts from its seed on `gen_reseed_o`.

The sequencer keeps three things: the number of words still held, a capped copy of that count for the status word, and a budget of regenerations left before a reseed is required. In continuous mode it refills the buffer on its own once half of the buffer has been read. A read from an empty or reset block returns a fixed marker word and changes no state. Completed commands raise a sticky done flag and send a one-cycle pulse to the interrupt logic. A soft reset sends a one-cycle clear pulse for the core interrupt.

Top module: `rng_word_seq`

## Requirements
- R1: The block is in reset while `ext_rst_i` is high or bit 0 (soft reset) of the stored control word is set. A control write made in reset performs no action, although its value still replaces the stored word. While `ext_rst_i` is high the stored word, the word count, the status count and the done flag are cleared.
- R2: A control write with bit 0 set, made outside reset, clears the word count, the status count and the done flag. It pulses `core_int_clr_o` for one cycle and starts no other action.
- R3: A control write outside reset with bit 0 clear and bit 5 (start) clear does nothing. With start set, bit 7 selects regenerate (1) or reseed (0). Either command sets the done flag in status bit 0 and pulses `done_pulse_o` for one cycle after the write.
- R4: A regenerate loads 8 words and sets the status count field (status bits 11:9) to 4. The word count never exceeds 8 and the field never exceeds 4.
- R5: An accepted read returns `gen_word_i`, pulses `gen_next_o` and lowers the word count by one. When the remaining count is below 4, the status count field shows the remaining count. Otherwise the field keeps its value.
- R6: A read in reset, with no words held, or in the same cycle as a control write returns 32'h00000BAD. It pulses no strobe and leaves the counts unchanged.
- R7: When the stored control word has start set and bit 9 (single-generation) clear, an accepted read that leaves 3 or fewer words starts an automatic regenerate in the same cycle. This regenerate does not set the done flag.
- R8: A reseed pulses `gen_reseed_o`, clears the word count, leaves the status count field unchanged and sets a budget of 2^BUDGET_W regenerations. Each regenerate uses one unit of budget. A regenerate that finds the budget at zero forces a reseed pulse first. The budget is zero after power-on reset.
- R9: `ctrl_rd_o` returns the stored control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_rst_i | input | 1 | External reset level |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 10 | Control word write data |
| ctrl_rd_o | output | 10 | Stored control word |
| out_re_i | input | 1 | Output word read strobe |
| out_data_o | output | 32 | Output word, or marker when unavailable |
| status_o | output | 12 | Bits 11:9 status count, bit 0 done |
| done_pulse_o | output | 1 | One-cycle command-done pulse |
| core_int_clr_o | output | 1 | One-cycle core interrupt clear pulse |
| gen_word_i | input | 32 | Current generator word |
| gen_next_o | output | 1 | Advance generator |
| gen_reseed_o | output | 1 | Restart generator from seed |

## Verification
Some properties are checked on every cycle: both counts stay within their caps, a clear empties the counters, an accepted read lowers the count by exactly one, an empty read leaves the count at zero, a continuous-mode read at the refill threshold refills to eight, and any reseed restores the budget. Other behaviour only the bench scenarios can show. This covers the exact word order from the generator, the status field holding at 4 and then tracking the count, writes ignored during soft reset, the status count kept across a reseed, and the forced reseed when the budget runs out. The bench uses a small budget width so that the budget can be exhausted.

// File: rtl/rng_seq_pkg.sv
// Package: shared constants for the random output word sequencer.
// Assumes a 10-bit control word and a 12-bit status word.
package rng_seq_pkg;
    localparam int CTRL_W      = 10;
    localparam int BIT_SRST    = 0;
    localparam int BIT_START   = 5;
    localparam int BIT_MODE    = 7;
    localparam int BIT_SINGLE  = 9;
    localparam int STAT_DONE   = 0;
    localparam int STAT_CNT_LSB = 9;
    localparam logic [31:0] EMPTY_MARK = 32'h0000_0BAD;
endpackage

// File: rtl/rng_seq_ctrl.sv
// Control decoder: stores the control word, works out the reset state
// and turns writes into soft-reset, reseed and regenerate commands.
// Assumes writes are single-cycle strobes.
module rng_seq_ctrl
    import rng_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_rst_i,
    input  logic              ctrl_we_i,
    input  logic [CTRL_W-1:0] ctrl_wdata_i,
    output logic [CTRL_W-1:0] ctrl_q_o,
    output logic              in_reset_o,
    output logic              soft_rst_o,
    output logic              cmd_reseed_o,
    output logic              cmd_regen_o,
    output logic              cont_mode_o,
    output logic              done_flag_o,
    output logic              done_pulse_o,
    output logic              core_int_clr_o
);
    logic [CTRL_W-1:0] ctrl_q;
    logic              done_q, done_p_q, clr_p_q;
    logic              act, cmd;

    // Decode a write into an action when the block is out of reset.
    always_comb begin
        in_reset_o   = ext_rst_i | ctrl_q[BIT_SRST];
        act          = ctrl_we_i & ~in_reset_o;
        soft_rst_o   = act & ctrl_wdata_i[BIT_SRST];
        cmd          = act & ~ctrl_wdata_i[BIT_SRST] & ctrl_wdata_i[BIT_START];
        cmd_regen_o  = cmd & ctrl_wdata_i[BIT_MODE];
        cmd_reseed_o = cmd & ~ctrl_wdata_i[BIT_MODE];
        cont_mode_o  = ctrl_q[BIT_START] & ~ctrl_q[BIT_SINGLE];
    end

    // Hold the last written control word; external reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n || ext_rst_i) ctrl_q <= '0;
        else if (ctrl_we_i)      ctrl_q <= ctrl_wdata_i;
    end

    // Sticky done flag plus the one-cycle done and clear pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q   <= 1'b0;
            done_p_q <= 1'b0;
            clr_p_q  <= 1'b0;
        end else begin
            done_p_q <= cmd;
            clr_p_q  <= soft_rst_o;
            if (ext_rst_i || soft_rst_o) done_q <= 1'b0;
            else if (cmd)                done_q <= 1'b1;
        end
    end

    assign ctrl_q_o       = ctrl_q;
    assign done_flag_o    = done_q;
    assign done_pulse_o   = done_p_q;
    assign core_int_clr_o = clr_p_q;

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse_o |-> done_flag_o)
        else $error("done pulse without done flag");

    p_ignore_in_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we_i && in_reset_o) |=> (!done_pulse_o && !core_int_clr_o))
        else $error("write acted during reset");
endmodule

// File: rtl/rng_word_counter.sv
// Word counter: tracks the words held and the capped count shown in status.
// Assumes at most one of load and empty per cycle; clear has priority.
module rng_word_counter #(
    parameter int BLOCK_WORDS = 8,
    parameter int STATUS_CAP  = 4,
    localparam int CNT_W = $clog2(BLOCK_WORDS + 1),
    localparam int QW    = $clog2(STATUS_CAP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             take_i,
    input  logic             empty_i,
    input  logic             load_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [QW-1:0]    qcnt_o
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BLOCK_WORDS);
    localparam logic [CNT_W-1:0] CAP_CNT  = CNT_W'(STATUS_CAP);
    localparam logic [QW-1:0]    CAP_Q    = QW'(STATUS_CAP);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [QW-1:0]    qcnt_q, qcnt_d;

    // Next counts: read first, then reseed clear, then block load.
    always_comb begin
        cnt_d  = cnt_q;
        qcnt_d = qcnt_q;
        if (take_i) begin
            cnt_d = cnt_q - 1'b1;
            if (cnt_d < CAP_CNT) qcnt_d = QW'(cnt_d);
        end
        if (empty_i) cnt_d = '0;
        if (load_i) begin
            cnt_d  = FULL_CNT;
            qcnt_d = CAP_Q;
        end
    end

    // Count registers.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q  <= '0;
            qcnt_q <= '0;
        end else begin
            cnt_q  <= cnt_d;
            qcnt_q <= qcnt_d;
        end
    end

    assign cnt_o  = cnt_q;
    assign qcnt_o = qcnt_q;

    p_cnt_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_CNT)
        else $error("word count above block size");

    p_qcnt_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        qcnt_q <= CAP_Q)
        else $error("status count above cap");

    p_take_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !load_i && !empty_i && !clr_i) |=> (cnt_q == $past(cnt_q) - 1'b1))
        else $error("read did not drop count by one");

    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0 && qcnt_q == '0))
        else $error("clear left counts");
endmodule

// File: rtl/rng_gen_budget.sv
// Generation budget: counts regenerations left since the last reseed and
// forces a reseed when a regenerate finds it exhausted.
// Assumes the budget starts at zero after power-on reset.
module rng_gen_budget #(
    parameter int BUDGET_W = 48,
    localparam int BW = BUDGET_W + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reseed_i,
    input  logic regen_i,
    output logic reseed_o
);
    localparam logic [BW-1:0] FULL = {1'b1, {BUDGET_W{1'b0}}};

    logic [BW-1:0] budget_q;

    // Reseed is requested explicitly or forced by an empty budget.
    assign reseed_o = reseed_i | (regen_i & (budget_q == '0));

    // Budget register: refill on reseed, then use one unit per regenerate.
    always_ff @(posedge clk) begin
        if (!rst_n)        budget_q <= '0;
        else if (reseed_o) budget_q <= regen_i ? FULL - 1'b1 : FULL;
        else if (regen_i)  budget_q <= budget_q - 1'b1;
    end

    p_budget_refill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reseed_o |=> (budget_q >= FULL - 1'b1))
        else $error("reseed did not refill budget");
endmodule

// File: rtl/rng_word_seq.sv
// Top: random output word sequencer. It serves 32-bit words from an external
// generator, keeps the counts and the budget, and refills in continuous mode.
// Assumes the generator shows its current word combinationally.
module rng_word_seq
    import rng_seq_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int BLOCK_WORDS = 8,
    parameter int STATUS_CAP  = 4,
    parameter int BUDGET_W    = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_rst_i,
    input  logic              ctrl_we_i,
    input  logic [CTRL_W-1:0] ctrl_wdata_i,
    output logic [CTRL_W-1:0] ctrl_rd_o,
    input  logic              out_re_i,
    output logic [WORD_W-1:0] out_data_o,
    output logic [STAT_CNT_LSB+$clog2(STATUS_CAP+1)-1:0] status_o,
    output logic              done_pulse_o,
    output logic              core_int_clr_o,
    input  logic [WORD_W-1:0] gen_word_i,
    output logic              gen_next_o,
    output logic              gen_reseed_o
);
    localparam int CNT_W = $clog2(BLOCK_WORDS + 1);
    localparam int QW    = $clog2(STATUS_CAP + 1);
    localparam logic [CNT_W-1:0] REFILL_CNT = CNT_W'(BLOCK_WORDS / 2);
    localparam logic [CNT_W-1:0] FULL_CNT   = CNT_W'(BLOCK_WORDS);

    logic             in_reset, soft_rst, cmd_reseed, cmd_regen, cont_mode, done_flag;
    logic [CNT_W-1:0] cnt;
    logic [QW-1:0]    qcnt;
    logic             take, auto_regen, regen_any;

    rng_seq_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_rst_i(ext_rst_i),
        .ctrl_we_i(ctrl_we_i), .ctrl_wdata_i(ctrl_wdata_i),
        .ctrl_q_o(ctrl_rd_o), .in_reset_o(in_reset), .soft_rst_o(soft_rst),
        .cmd_reseed_o(cmd_reseed), .cmd_regen_o(cmd_regen),
        .cont_mode_o(cont_mode), .done_flag_o(done_flag),
        .done_pulse_o(done_pulse_o), .core_int_clr_o(core_int_clr_o)
    );

    // Accept a read only when words are held and nothing else is in progress.
    always_comb begin
        take       = out_re_i & ~in_reset & ~ctrl_we_i & (cnt != '0);
        auto_regen = take & cont_mode & (cnt <= REFILL_CNT);
        regen_any  = cmd_regen | auto_regen;
        out_data_o = take ? gen_word_i : WORD_W'(EMPTY_MARK);
        gen_next_o = take;
    end

    rng_word_counter #(.BLOCK_WORDS(BLOCK_WORDS), .STATUS_CAP(STATUS_CAP)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr_i(ext_rst_i | soft_rst),
        .take_i(take), .empty_i(cmd_reseed), .load_i(regen_any),
        .cnt_o(cnt), .qcnt_o(qcnt)
    );

    rng_gen_budget #(.BUDGET_W(BUDGET_W)) u_budget (
        .clk(clk), .rst_n(rst_n), .reseed_i(cmd_reseed), .regen_i(regen_any),
        .reseed_o(gen_reseed_o)
    );

    // Status word: capped count in the upper field, done flag in bit 0.
    always_comb begin
        status_o = '0;
        status_o[STAT_CNT_LSB +: QW] = qcnt;
        status_o[STAT_DONE] = done_flag;
    end

    p_empty_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_re_i && !ctrl_we_i && cnt == '0) |=> (cnt == '0))
        else $error("empty read changed count");

    p_auto_refill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cont_mode && cnt <= REFILL_CNT && !ext_rst_i) |=> (cnt == FULL_CNT))
        else $error("continuous refill missed");
endmodule

// File: tb/sim_rng_word_seq.sv
module sim_rng_word_seq;
    localparam logic [31:0] SEED = 32'h1234_5678;
    localparam logic [31:0] BAD  = 32'h0000_0BAD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_rst = 1'b1;
    logic        ctrl_we = 1'b0;
    logic [9:0]  ctrl_wdata = '0;
    logic        out_re = 1'b0;
    logic [9:0]  ctrl_rd;
    logic [31:0] out_data;
    logic [11:0] status;
    logic        done_pulse, core_clr, gen_next, gen_reseed;
    logic [31:0] model = SEED;

    int checks = 0;
    int fails  = 0;
    int rs_cnt = 0;
    bit ended  = 0;

    logic [31:0] obs_data, exp_word;
    logic        obs_next, obs_rs;

    always #5 clk = ~clk;

    rng_word_seq #(.BUDGET_W(2)) u0 (
        .clk(clk), .rst_n(rst_n), .ext_rst_i(ext_rst),
        .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata), .ctrl_rd_o(ctrl_rd),
        .out_re_i(out_re), .out_data_o(out_data), .status_o(status),
        .done_pulse_o(done_pulse), .core_int_clr_o(core_clr),
        .gen_word_i(model), .gen_next_o(gen_next), .gen_reseed_o(gen_reseed)
    );

    function automatic logic [31:0] nxt(input logic [31:0] w);
        return {w[30:0], w[31] ^ w[21] ^ w[1] ^ w[0]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock: drive inputs, sample combinational outputs mid-cycle,
    // cross the edge, then advance the generator model.
    task automatic cycle(input bit we, input logic [9:0] wd, input bit re);
        ctrl_we = we; ctrl_wdata = wd; out_re = re;
        #4;
        obs_data = out_data; obs_next = gen_next; obs_rs = gen_reseed;
        exp_word = model;
        @(posedge clk); #1;
        if (obs_rs) begin rs_cnt++; model = SEED; end
        else if (obs_next) model = nxt(model);
        ctrl_we = 1'b0; out_re = 1'b0;
    endtask

    // {op(1=write), wdata, expected status, expect marker, expected reseeds}
    localparam int NV = 25;
    localparam logic [28:0] VEC [NV] = '{
        {2'd0, 10'h000, 12'h000, 1'b1, 4'd0},  // R6 empty read
        {2'd1, 10'h220, 12'h001, 1'b0, 4'd1},  // R3 R8 reseed
        {2'd1, 10'h2A0, 12'h801, 1'b0, 4'd1},  // R4 regen
        {2'd0, 10'h000, 12'h801, 1'b0, 4'd1},  // R5
        {2'd0, 10'h000, 12'h801, 1'b0, 4'd1},
        {2'd0, 10'h000, 12'h801, 1'b0, 4'd1},
        {2'd0, 10'h000, 12'h801, 1'b0, 4'd1},
        {2'd0, 10'h000, 12'h601, 1'b0, 4'd1},
        {2'd0, 10'h000, 12'h401, 1'b0, 4'd1},
        {2'd0, 10'h000, 12'h201, 1'b0, 4'd1},
        {2'd0, 10'h000, 12'h001, 1'b0, 4'd1},
        {2'd0, 10'h000, 12'h001, 1'b1, 4'd1},  // R6 drained
        {2'd1, 10'h001, 12'h000, 1'b0, 4'd1},  // R2 soft reset
        {2'd1, 10'h2A0, 12'h000, 1'b0, 4'd1},  // R1 ignored in reset
        {2'd0, 10'h000, 12'h000, 1'b1, 4'd1},
        {2'd1, 10'h0A0, 12'h801, 1'b0, 4'd1},  // R7 continuous regen
        {2'd0, 10'h000, 12'h801, 1'b0, 4'd1},
        {2'd0, 10'h000, 12'h801, 1'b0, 4'd1},
        {2'd0, 10'h000, 12'h801, 1'b0, 4'd1},
        {2'd0, 10'h000, 12'h801, 1'b0, 4'd1},
        {2'd0, 10'h000, 12'h801, 1'b0, 4'd1},  // R7 auto refill
        {2'd0, 10'h000, 12'h801, 1'b0, 4'd1},
        {2'd1, 10'h020, 12'h801, 1'b0, 4'd2},  // R8 count kept
        {2'd0, 10'h000, 12'h801, 1'b1, 4'd2},
        {2'd1, 10'h000, 12'h801, 1'b0, 4'd2}   // R3 start clear
    };

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        checks++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1 ext_rst = 1'b0;
        // Reset state
        check(status == 12'h000, "R1 reset status", 32'(status), 32'h0);
        check(ctrl_rd == 10'h000, "R9 reset ctrl", 32'(ctrl_rd), 32'h0);
        check(done_pulse == 1'b0, "R3 reset pulse", 32'(done_pulse), 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [28:0] v;
            v = VEC[i];
            cycle(v[27], v[26:17], ~v[27]);
            if (!v[27]) begin
                if (v[4]) check(obs_data == BAD && !obs_next, "R6 marker read", obs_data, BAD);
                else      check(obs_data == exp_word && obs_next, "R5 word read", obs_data, exp_word);
            end else begin
                check(ctrl_rd == v[26:17], "R9 readback", 32'(ctrl_rd), 32'(v[26:17]));
            end
            check(status == v[16:5], $sformatf("R4 status row %0d", i), 32'(status), 32'(v[16:5]));
            check(rs_cnt == int'(v[3:0]), $sformatf("R8 reseeds row %0d", i), 32'(rs_cnt), 32'(v[3:0]));
        end

        // R3: done pulse lasts one cycle
        cycle(1'b1, 10'h220, 1'b0);
        check(done_pulse == 1'b1, "R3 pulse high", 32'(done_pulse), 32'h1);
        cycle(1'b0, 10'h000, 1'b0);
        check(done_pulse == 1'b0, "R3 pulse one cycle", 32'(done_pulse), 32'h0);

        // R8: budget of 4 after reseed, 5th regenerate forces a reseed
        for (int k = 0; k < 4; k++) cycle(1'b1, 10'h2A0, 1'b0);
        check(rs_cnt == 3, "R8 budget not yet exhausted", 32'(rs_cnt), 32'd3);
        check(status == 12'h801, "R4 regen status", 32'(status), 32'h801);
        cycle(1'b1, 10'h2A0, 1'b0);
        check(rs_cnt == 4, "R8 forced reseed", 32'(rs_cnt), 32'd4);

        // R6: read together with a control write gives the marker
        cycle(1'b1, 10'h200, 1'b1);
        check(obs_data == BAD && !obs_next, "R6 read during write", obs_data, BAD);
        cycle(1'b0, 10'h000, 1'b1);
        check(obs_data == exp_word && obs_next, "R5 read after write", obs_data, exp_word);
        check(status == 12'h801, "R5 count held at cap", 32'(status), 32'h801);

        // R2: soft reset pulses the core interrupt clear
        cycle(1'b1, 10'h001, 1'b0);
        check(core_clr == 1'b1 && status == 12'h000, "R2 clear pulse", 32'(core_clr), 32'h1);
        cycle(1'b1, 10'h200, 1'b0);
        check(core_clr == 1'b0, "R2 pulse one cycle", 32'(core_clr), 32'h0);

        // R1: external reset clears state and blocks writes
        cycle(1'b1, 10'h2A0, 1'b0);
        check(status == 12'h801, "R4 regen before ext reset", 32'(status), 32'h801);
        ext_rst = 1'b1;
        cycle(1'b0, 10'h000, 1'b1);
        check(obs_data == BAD, "R1 read in ext reset", obs_data, BAD);
        check(status == 12'h000 && ctrl_rd == 10'h000, "R1 ext reset clears", 32'(status), 32'h0);
        cycle(1'b1, 10'h2A0, 1'b0);
        check(status == 12'h000, "R1 write ignored in ext reset", 32'(status), 32'h0);
        ext_rst = 1'b0;
        cycle(1'b0, 10'h000, 1'b0);
        check(status == 12'h000, "R1 after ext reset", 32'(status), 32'h0);

        finish_run();
    end
endmodule